// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block loads a bitstream into a target FPGA through that device's byte-wide slave configuration port. When a load starts, the block pulses the active-low program line. It then waits while the target clears its configuration memory, which the target shows by holding its init status low. Once init returns high, the block moves bitstream bytes from a valid/ready byte stream onto an 8-bit data bus. Each byte gets one rising edge of a configuration clock, and that clock is divided down from the system clock.

The source marks the last byte with an end-of-stream flag. After that byte, the block keeps toggling the configuration clock, with no new data, until the target raises done. The result is reported as success, CRC error or timeout:
- A CRC error is reported if init falls at any point during streaming or during the clocking after the last byte.
- A timeout is reported if either init wait runs out, or if the clocking after the last byte runs out before done rises.

Two options are chosen when a load starts:
- The bit order inside every byte can be reversed.
- If the previous load failed, the block can first hold the target's power-enable line off for a set interval, giving the target a full power cycle before the retry.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, busy=0, prog_n=1, pwr_en=1, cfg_clk=0, s_ready=0, and done_ok, crc_err and timeout_err are all 0.
- R2: A start pulse seen while idle drives prog_n low from the next cycle for max(prog_cycles,1) system clocks, then releases it. A start pulse while busy is ignored, and no second program pulse occurs.
- R3: After prog_n is released, the block waits for init_n to go low and then waits for it to go high again. Each wait is bounded by max(init_limit,1) clocks. If either bound expires, the load ends with timeout_err and no cfg_clk edge occurs.
- R4: s_ready is high only during the streaming phase, only while cfg_clk is low and no byte is held. A byte is taken on a clock edge where s_valid and s_ready are both high.
- R5: After a byte is taken, cfg_clk stays low for D clocks and then stays high for D clocks, where D = max(half_div,1). Each byte gets exactly one rising edge, and cfg_d never changes while cfg_clk is high.
- R6: swap_bits is sampled at start. When it is 1, cfg_d[i] equals byte bit [7-i] for the whole load. When it is 0, cfg_d equals the byte unchanged.
- R7: If init_n is low during streaming or during the clocking after the last byte, the load ends with crc_err and cfg_clk stops.
- R8: After the byte flagged s_last completes its high phase, cfg_clk keeps toggling with half period D and s_ready stays low. When done is seen high, the load ends with done_ok.
- R9: The clocking after the last byte lasts at most max(flush_limit,1) clocks. If done is still low at the end, the load ends with timeout_err. If done is seen in that final clock, done_ok wins.
- R10: When a load ends, exactly one of done_ok, crc_err and timeout_err is set, and it is held until the next accepted start, which clears all three. busy is high from the cycle after start until the load ends.
- R11: If pwr_cycle_req is 1 at start and the previous load ended in crc_err or timeout_err, pwr_en goes low for max(pwr_off_cycles,1) clocks before the program pulse. In every other case, pwr_en stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (taken only when idle) |
| swap_bits | input | 1 | Reverse bit order in each byte for this load |
| pwr_cycle_req | input | 1 | Power-cycle the target first if the last load failed |
| half_div | input | DIVW | Configuration clock half period in system clocks (0 acts as 1) |
| prog_cycles | input | CW | Program pulse width in clocks (0 acts as 1) |
| init_limit | input | CW | Bound on each init wait, in clocks |
| flush_limit | input | CW | Bound on the clocking after the last byte, in clocks |
| pwr_off_cycles | input | CW | Power-off interval in clocks (0 acts as 1) |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | DW | Byte stream data |
| s_last | input | 1 | Marks the final byte |
| s_ready | output | 1 | Block takes the byte |
| prog_n | output | 1 | Active-low program line to the target |
| init_n | input | 1 | Target init status (low = clearing or CRC error) |
| done | input | 1 | Target done status |
| cfg_clk | output | 1 | Configuration clock |
| cfg_d | output | DW | Configuration data bus |
| pwr_en | output | 1 | Target power enable |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Last load succeeded |
| crc_err | output | 1 | Last load ended on init falling |
| timeout_err | output | 1 | Last load ended on an expired bound |

## Verification
Two of this block's functions can fall in the same cycle. The target may raise done in the very clock where the post-data bound expires, and the two outcomes must not both be reported.

The bench provokes this with a half period of two clocks and a bound of three clocks. Under those settings the only post-data rising edge lands one clock before expiry, so the target model's done is first seen in the expiring clock. With that setting the bench expects done_ok. It then requires one more edge before done rises, and in that case it expects timeout_err with no extra edge.

Around this, sweeps over half period, bit-swap and byte count compare the captured bus bytes, the edge counts and the high-phase widths against values the bench computes arithmetically.

// File: rtl/cfgld_pkg.sv
// Shared types for the configuration loader.
package cfgld_pkg;

    // Load sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_OFF,
        ST_PROG,
        ST_WAIT_CLR,
        ST_WAIT_RDY,
        ST_STREAM,
        ST_FLUSH
    } cfg_state_e;

    // Outcome of a load, raised for one cycle when the sequencer returns to idle.
    typedef enum logic [1:0] {
        RES_NONE,
        RES_OK,
        RES_CRC,
        RES_TMO
    } cfg_result_e;

endpackage

// File: rtl/cfgld_timer.sv
// Interval counter shared by the sequencer's timed phases.
// Counts system clocks since the last clear and raises hit on the
// max(limit,1)-th clock, then holds. Assumes limit is stable within a phase.
module cfgld_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] eff_lim;

    // Zero limit behaves as one.
    always_comb eff_lim = (limit == '0) ? ONE : limit;

    // Hit flags the last clock of the interval.
    always_comb hit = (cnt == eff_lim - ONE);

    // Count up from the clear point and saturate at hit.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (!hit)     cnt <= cnt + ONE;
    end
endmodule

// File: rtl/cfgld_bitorder.sv
// Optional bit reversal of one data word (bit 0 with bit W-1 and so on).
// Purely combinational.
module cfgld_bitorder #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         swap,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev;

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign rev[g] = din[W-1-g];
    end

    // Pick reversed or straight order.
    always_comb dout = swap ? rev : din;
endmodule

// File: rtl/cfgld_cclk_gen.sv
// Configuration clock and data engine.
// Streaming mode: it takes one byte while the clock is low, holds the clock
// low for D clocks, then high for D clocks, then frees the byte slot.
// Flush mode: it toggles the clock every D clocks with no data.
// D = max(half_div,1). When en drops, everything returns low in the next
// cycle. Assumes en and flush are driven from the sequencer's next state.
module cfgld_cclk_gen #(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            flush,
    input  logic            stream_now,
    input  logic [DIVW-1:0] half_div,
    input  logic            s_valid,
    input  logic [DW-1:0]   s_data,
    input  logic            s_last,
    output logic            s_ready,
    output logic            cfg_clk,
    output logic [DW-1:0]   cfg_d,
    output logic            last_end
);
    localparam logic [DIVW-1:0] ONE = DIVW'(1);

    logic [DIVW-1:0] eff_div;
    logic [DIVW-1:0] hc;
    logic            hc_hit;
    logic            clk_q;
    logic            have;
    logic            last_q;
    logic [DW-1:0]   d_q;

    // Half period, with zero treated as one.
    always_comb eff_div = (half_div == '0) ? ONE : half_div;
    // Last clock of the current half period.
    always_comb hc_hit  = (hc == eff_div - ONE);

    // Byte slot open: streaming, clock low, nothing held.
    always_comb s_ready  = stream_now && !clk_q && !have;
    // Final byte's high phase ends on this edge.
    always_comb last_end = stream_now && clk_q && hc_hit && last_q;

    always_comb cfg_clk = clk_q;
    always_comb cfg_d   = d_q;

    // Clock phase, byte slot and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            hc     <= '0;
            have   <= 1'b0;
            last_q <= 1'b0;
            d_q    <= '0;
        end else if (!en) begin
            clk_q  <= 1'b0;
            hc     <= '0;
            have   <= 1'b0;
            last_q <= 1'b0;
        end else if (!clk_q) begin
            if (!have && !flush) begin
                if (s_ready && s_valid) begin
                    d_q    <= s_data;
                    have   <= 1'b1;
                    last_q <= s_last;
                    hc     <= '0;
                end
            end else if (hc_hit) begin
                clk_q <= 1'b1;
                hc    <= '0;
            end else begin
                hc <= hc + ONE;
            end
        end else begin
            if (hc_hit) begin
                clk_q <= 1'b0;
                hc    <= '0;
                have  <= 1'b0;
            end else begin
                hc <= hc + ONE;
            end
        end
    end
endmodule

// File: rtl/fpga_cfg_loader.sv
// Byte-wide configuration loader for a target FPGA.
// It sequences an optional power-off, the program pulse, the two init
// waits, byte streaming and the clocking after the last byte, and it
// reports one outcome flag per load. Assumes the limit and divider inputs
// stay stable during a load, and that init_n and done are synchronous to
// clk (any synchronisers sit outside this block).
module fpga_cfg_loader #(
    parameter int DW   = 8,
    parameter int CW   = 16,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            swap_bits,
    input  logic            pwr_cycle_req,
    input  logic [DIVW-1:0] half_div,
    input  logic [CW-1:0]   prog_cycles,
    input  logic [CW-1:0]   init_limit,
    input  logic [CW-1:0]   flush_limit,
    input  logic [CW-1:0]   pwr_off_cycles,
    input  logic            s_valid,
    input  logic [DW-1:0]   s_data,
    input  logic            s_last,
    output logic            s_ready,
    output logic            prog_n,
    input  logic            init_n,
    input  logic            done,
    output logic            cfg_clk,
    output logic [DW-1:0]   cfg_d,
    output logic            pwr_en,
    output logic            busy,
    output logic            done_ok,
    output logic            crc_err,
    output logic            timeout_err
);
    import cfgld_pkg::*;

    cfg_state_e    state, state_d;
    cfg_result_e   res;
    logic [CW-1:0] lim;
    logic          t_hit;
    logic          swap_q;
    logic          last_end;
    logic          eng_en;
    logic          eng_flush;
    logic          take_start;
    logic [DW-1:0] ordered;

    // A start counts only while idle.
    always_comb take_start = (state == ST_IDLE) && start;

    // Next state and outcome of the load sequencer.
    always_comb begin
        state_d = state;
        res     = RES_NONE;
        case (state)
            ST_IDLE: begin
                if (start)
                    state_d = (pwr_cycle_req && (crc_err || timeout_err))
                              ? ST_PWR_OFF : ST_PROG;
            end
            ST_PWR_OFF: begin
                if (t_hit) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (t_hit) state_d = ST_WAIT_CLR;
            end
            ST_WAIT_CLR: begin
                if (!init_n)      state_d = ST_WAIT_RDY;
                else if (t_hit) begin state_d = ST_IDLE; res = RES_TMO; end
            end
            ST_WAIT_RDY: begin
                if (init_n)       state_d = ST_STREAM;
                else if (t_hit) begin state_d = ST_IDLE; res = RES_TMO; end
            end
            ST_STREAM: begin
                if (!init_n)       begin state_d = ST_IDLE; res = RES_CRC; end
                else if (last_end) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (!init_n)     begin state_d = ST_IDLE; res = RES_CRC; end
                else if (done)   begin state_d = ST_IDLE; res = RES_OK;  end
                else if (t_hit)  begin state_d = ST_IDLE; res = RES_TMO; end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Limit that applies to the phase now running.
    always_comb begin
        case (state)
            ST_PWR_OFF:              lim = pwr_off_cycles;
            ST_WAIT_CLR, ST_WAIT_RDY: lim = init_limit;
            ST_FLUSH:                lim = flush_limit;
            default:                 lim = prog_cycles;
        endcase
    end

    // Clock engine runs whenever the next state streams or flushes.
    always_comb eng_en    = (state_d == ST_STREAM) || (state_d == ST_FLUSH);
    always_comb eng_flush = (state_d == ST_FLUSH);

    // Line outputs decoded from the current state.
    always_comb busy   = (state != ST_IDLE);
    always_comb prog_n = (state != ST_PROG);
    always_comb pwr_en = (state != ST_PWR_OFF);

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Bit-order choice held for the whole load.
    always_ff @(posedge clk) begin
        if (!rst_n)          swap_q <= 1'b0;
        else if (take_start) swap_q <= swap_bits;
    end

    // Outcome flags: cleared by an accepted start, set by the finishing edge.
    always_ff @(posedge clk) begin
        if (!rst_n || take_start) begin
            done_ok     <= 1'b0;
            crc_err     <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            case (res)
                RES_OK:  done_ok     <= 1'b1;
                RES_CRC: crc_err     <= 1'b1;
                RES_TMO: timeout_err <= 1'b1;
                default: ;
            endcase
        end
    end

    cfgld_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state),
        .limit (lim),
        .hit   (t_hit)
    );

    cfgld_bitorder #(.W(DW)) u_order (
        .din  (s_data),
        .swap (swap_q),
        .dout (ordered)
    );

    cfgld_cclk_gen #(.DW(DW), .DIVW(DIVW)) u_cclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (eng_en),
        .flush      (eng_flush),
        .stream_now (state == ST_STREAM),
        .half_div   (half_div),
        .s_valid    (s_valid),
        .s_data     (ordered),
        .s_last     (s_last),
        .s_ready    (s_ready),
        .cfg_clk    (cfg_clk),
        .cfg_d      (cfg_d),
        .last_end   (last_end)
    );
endmodule

// File: rtl/cfgld_checker.sv
// Temporal checks on the loader's ports, attached by bind below.
module cfgld_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          prog_n,
    input logic          pwr_en,
    input logic          cfg_clk,
    input logic [DW-1:0] cfg_d,
    input logic          s_ready,
    input logic          done_ok,
    input logic          crc_err,
    input logic          timeout_err
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && pwr_en && !cfg_clk && !s_ready));

    p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (!cfg_clk && !s_ready && pwr_en));

    p_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!cfg_clk && busy));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_d));

    p_crc_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> (!busy && !cfg_clk));

    p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done_ok, crc_err, timeout_err}) <= 1);

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !(done_ok || crc_err || timeout_err));

    p_pwr_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (prog_n && busy && !cfg_clk));
endmodule

bind fpga_cfg_loader cfgld_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .prog_n      (prog_n),
    .pwr_en      (pwr_en),
    .cfg_clk     (cfg_clk),
    .cfg_d       (cfg_d),
    .s_ready     (s_ready),
    .done_ok     (done_ok),
    .crc_err     (crc_err),
    .timeout_err (timeout_err)
);

// File: tb/fpga_cfg_loader_tb.sv
`timescale 1ns/1ps
module fpga_cfg_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        swap_bits = 1'b0;
    logic        pwr_cycle_req = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic [15:0] prog_cycles = 16'd1;
    logic [15:0] init_limit = 16'd20;
    logic [15:0] flush_limit = 16'd200;
    logic [15:0] pwr_off_cycles = 16'd4;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'd0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        prog_n;
    logic        init_n = 1'b1;
    logic        done = 1'b0;
    logic        cfg_clk;
    logic [7:0]  cfg_d;
    logic        pwr_en;
    logic        busy;
    logic        done_ok;
    logic        crc_err;
    logic        timeout_err;

    int checks = 0;
    int failures = 0;

    fpga_cfg_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .swap_bits(swap_bits),
        .pwr_cycle_req(pwr_cycle_req), .half_div(half_div),
        .prog_cycles(prog_cycles), .init_limit(init_limit),
        .flush_limit(flush_limit), .pwr_off_cycles(pwr_off_cycles),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .prog_n(prog_n), .init_n(init_n), .done(done), .cfg_clk(cfg_clk),
        .cfg_d(cfg_d), .pwr_en(pwr_en), .busy(busy), .done_ok(done_ok),
        .crc_err(crc_err), .timeout_err(timeout_err)
    );

    always #2 clk = ~clk;

    // Target model settings
    int clr_start = 2;
    int clr_len   = 5;
    bit no_clear  = 1'b0;
    bit stuck_low = 1'b0;
    int crc_at    = 0;
    int done_at   = 1000000;
    int cur_div   = 1;

    // Target model state and measurements
    int   pc = 0;
    bit   armed = 1'b0;
    bit   crc_latch = 1'b0;
    int   rises = 0;
    int   hi_run = 0;
    int   prog_low_cnt = 0;
    int   pwr_low_cnt = 0;
    int   prog_falls = 0;
    int   run_viol = 0;
    int   dchg_viol = 0;
    logic prev_clk = 1'b0;
    logic prev_prog = 1'b1;
    logic [7:0] prev_d = 8'd0;
    logic [7:0] cap [0:63];

    // Target device model, evaluated away from the active edge
    always @(negedge clk) begin
        if (!prog_n) begin
            pc = 0; rises = 0; crc_latch = 1'b0; armed = 1'b1;
            prog_low_cnt++;
            if (prev_prog) prog_falls++;
        end else begin
            pc++;
        end
        if (!pwr_en) pwr_low_cnt++;
        if (cfg_clk && !prev_clk) begin
            if (rises < 64) cap[rises] = cfg_d;
            rises++;
            hi_run = 1;
            if (crc_at != 0 && rises == crc_at) crc_latch = 1'b1;
        end else if (cfg_clk) begin
            hi_run++;
            if (cfg_d != prev_d) dchg_viol++;
        end else if (prev_clk && busy && hi_run != cur_div) begin
            run_viol++;
        end
        if (crc_latch)
            init_n = 1'b0;
        else if (armed && !no_clear && pc >= clr_start &&
                 (stuck_low || pc < clr_start + clr_len))
            init_n = 1'b0;
        else
            init_n = 1'b1;
        done = (rises >= done_at);
        prev_clk = cfg_clk; prev_prog = prog_n; prev_d = cfg_d;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = v[7 - k];
        return r;
    endfunction

    task automatic clear_meas();
        prog_low_cnt = 0; pwr_low_cnt = 0; prog_falls = 0;
        run_viol = 0; dchg_viol = 0;
    endtask

    task automatic send_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            bit acc = 1'b0;
            s_valid = 1'b1; s_data = pat(i, seed); s_last = (i == n - 1);
            while (!acc && busy) begin
                if (s_ready) acc = 1'b1;
                @(negedge clk);
            end
            if (!acc) break;
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 20000) begin @(negedge clk); k++; end
        chk(!busy, "wait_idle", int'(busy), 0);
    endtask

    task automatic pulse_start(input bit sw, input bit preq);
        swap_bits = sw; pwr_cycle_req = preq;
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic do_load(input int n, input int seed, input bit sw, input bit preq);
        clear_meas();
        pulse_start(sw, preq);
        send_bytes(n, seed);
        wait_idle();
    endtask

    task automatic set_div(input int d);
        half_div = 8'(d); cur_div = (d == 0) ? 1 : d;
    endtask

    function automatic int bytes_bad(input int n, input int seed, input bit sw);
        int bad = 0;
        for (int i = 0; i < n; i++)
            if (cap[i] != (sw ? rev8(pat(i, seed)) : pat(i, seed))) bad++;
        return bad;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && prog_n && pwr_en, "R1 idle lines", int'({busy, prog_n, pwr_en}), 3'b011);
        chk(!cfg_clk && !s_ready, "R1 clock/ready", int'({cfg_clk, s_ready}), 0);
        chk(!done_ok && !crc_err && !timeout_err, "R1 flags",
            int'({done_ok, crc_err, timeout_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && prog_n && !cfg_clk, "R1 after release", int'({busy, prog_n, cfg_clk}), 3'b010);

        // Sweep: half period, bit order, byte count (R2 R5 R6 R8 R10 R11)
        for (int d = 1; d <= 3; d++) begin
            for (int sw = 0; sw <= 1; sw++) begin
                for (int ns = 0; ns <= 1; ns++) begin
                    int n = ns ? 5 : 1;
                    int seed = d * 4 + sw * 2 + ns;
                    set_div(d);
                    prog_cycles = 16'(d - 1);
                    flush_limit = 16'd200;
                    done_at = n + 2;
                    do_load(n, seed, sw[0], 1'b0);
                    chk(prog_low_cnt == ((d - 1) == 0 ? 1 : d - 1), "R2 program width",
                        prog_low_cnt, (d - 1) == 0 ? 1 : d - 1);
                    chk(done_ok && !crc_err && !timeout_err, "R10 single ok flag",
                        int'({done_ok, crc_err, timeout_err}), 3'b100);
                    chk(rises == n + 2, "R8 edges until done", rises, n + 2);
                    chk(bytes_bad(n, seed, sw[0]) == 0, sw ? "R6 swapped bytes" : "R5 bytes",
                        bytes_bad(n, seed, sw[0]), 0);
                    chk(run_viol == 0, "R5 high phase width", run_viol, 0);
                    chk(dchg_viol == 0, "R5 data stable while high", dchg_viol, 0);
                    chk(pwr_low_cnt == 0, "R11 no power cycle", pwr_low_cnt, 0);
                end
            end
        end

        // R2 start while busy ignored
        set_div(2); prog_cycles = 16'd3; done_at = 5;
        clear_meas();
        swap_bits = 1'b0; start = 1'b1;
        repeat (4) @(negedge clk);
        start = 1'b0;
        send_bytes(3, 9);
        wait_idle();
        chk(prog_falls == 1, "R2 start while busy", prog_falls, 1);
        chk(done_ok && bytes_bad(3, 9, 1'b0) == 0, "R2 load intact", int'(done_ok), 1);

        // R3 init never falls
        no_clear = 1'b1; init_limit = 16'd10;
        do_load(3, 1, 1'b0, 1'b0);
        chk(timeout_err && !done_ok && !crc_err, "R3 no clear timeout",
            int'({done_ok, crc_err, timeout_err}), 3'b001);
        chk(rises == 0, "R3 no clock edge", rises, 0);
        no_clear = 1'b0;

        // R11 power cycle after failure
        pwr_off_cycles = 16'd4; done_at = 4;
        clear_meas();
        pulse_start(1'b0, 1'b1);
        chk(!done_ok && !crc_err && !timeout_err, "R10 flags cleared", 
            int'({done_ok, crc_err, timeout_err}), 0);
        send_bytes(2, 3);
        wait_idle();
        chk(pwr_low_cnt == 4, "R11 power off width", pwr_low_cnt, 4);
        chk(done_ok, "R11 load after power cycle", int'(done_ok), 1);

        // R11 power cycle request after success is ignored
        do_load(2, 3, 1'b0, 1'b1);
        chk(pwr_low_cnt == 0, "R11 no cycle after success", pwr_low_cnt, 0);

        // R3 init stuck low
        stuck_low = 1'b1;
        do_load(3, 1, 1'b0, 1'b0);
        chk(timeout_err && rises == 0, "R3 stuck init timeout", rises, 0);
        stuck_low = 1'b0;

        // R11 zero power interval acts as one
        pwr_off_cycles = 16'd0;
        do_load(2, 3, 1'b0, 1'b1);
        chk(pwr_low_cnt == 1, "R11 zero interval", pwr_low_cnt, 1);

        // R7 CRC error while streaming
        set_div(1); prog_cycles = 16'd1;
        crc_at = 2; done_at = 1000000;
        do_load(5, 6, 1'b0, 1'b0);
        chk(crc_err && !done_ok && !timeout_err, "R7 crc in stream",
            int'({done_ok, crc_err, timeout_err}), 3'b010);
        chk(rises == 2, "R7 clock stops", rises, 2);

        // R7 CRC error during post-data clocking; R10 flags cleared at start
        crc_at = 4;
        clear_meas();
        pulse_start(1'b0, 1'b0);
        chk(!crc_err, "R10 crc flag cleared", int'(crc_err), 0);
        send_bytes(3, 7);
        wait_idle();
        chk(crc_err && !timeout_err, "R7 crc in flush", int'({crc_err, timeout_err}), 2'b10);
        crc_at = 0;

        // R9 flush bound expiry, rising edges = n + ((L-1)/D + 1)/2
        set_div(1); flush_limit = 16'd7;
        do_load(2, 2, 1'b0, 1'b0);
        chk(timeout_err && !done_ok, "R9 flush timeout", int'(timeout_err), 1);
        chk(rises == 2 + 3, "R9 edges before timeout D1", rises, 5);
        set_div(3); flush_limit = 16'd10;
        do_load(2, 2, 1'b1, 1'b0);
        chk(rises == 2 + 2, "R9 edges before timeout D3", rises, 4);
        chk(bytes_bad(2, 2, 1'b1) == 0, "R6 swapped under timeout", bytes_bad(2, 2, 1'b1), 0);

        // R9 done seen in the expiring clock wins
        set_div(2); flush_limit = 16'd3; done_at = 3;
        do_load(2, 8, 1'b0, 1'b0);
        chk(done_ok && !timeout_err, "R9 done in last clock",
            int'({done_ok, timeout_err}), 2'b10);
        done_at = 4;
        do_load(2, 8, 1'b0, 1'b0);
        chk(timeout_err && !done_ok && rises == 3, "R9 one edge short", rises, 3);

        // R4 ready low when idle
        @(negedge clk);
        chk(!s_ready && !cfg_clk, "R4 idle ready", int'(s_ready), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule